// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a 32-bit processor core from normal execution into an exception handler. While idle it watches four entry causes: a bus fault and a break, both raised by the core, plus a non-maskable interrupt and a maskable interrupt from outside. It picks one of them and takes a snapshot of the core state it needs. It then works out, in a single cycle, every register the handler will find: the return address in the register that matches the cause, the vector index in the status word, the shifted condition register and the stack pointer pair.

Next it reads the handler address from a table of 32-bit words at base plus four times the vector index. It uses a single-word read port and holds the request until the memory acknowledges. The core then gets a one-cycle completion pulse. The new program counter, the register values and their write enables are all valid in that cycle. Requests that arrive while a sequence is in flight are not looked at.

Top module: `exc_entry_seq`

## Requirements
- R1: A maskable interrupt is accepted only when `irq_pend` is high, bit `I_BIT` (default 6) of `ccs_in` is set and `irq_lock` is low. Its vector index is `irq_vec`.
- R2: A non-maskable interrupt is accepted only when `nmi_pend` is high and the enable flag is set. That flag is bit `M_BIT_OLD` (default 9) of `ccs_in` when `ver_in` is below `VER_SPLIT` (default 32), and bit `M_BIT_NEW` (default 30) otherwise.
- R3: In the idle state `accept` is high for exactly the cycle in which an acceptable request is present. `cause` then reports the chosen cause, with priority from highest to lowest: bus fault (`bf_req`, code 3), break (`brk_req`, code 2), non-maskable interrupt (code 1), maskable interrupt (code 0).
- R4: A non-maskable entry uses vector index 0. It clears the enable flag chosen by R2 before the shift of R9, writes the return address through `nrp_out`/`nrp_we` and leaves `erp_we` low.
- R5: Bus fault, break and maskable interrupt use `bf_vec`, `brk_vec` and `irq_vec` respectively. They write the return address through `erp_out`/`erp_we` and leave `nrp_we` low.
- R6: `exs_out` holds the low 8 bits of the vector index at bits 15:8, with every other bit zero.
- R7: The saved return address is `pc_in` minus `dslot_in`. `dslot_clr` is high with `done` exactly when `dslot_in` was nonzero.
- R8: When bit `U_BIT` (default 8) of `ccs_in` is set, `usp_out` takes `sp_in`, `usp_we` is high with `done`, and `sp_out` takes `ksp_in`. Otherwise `usp_we` is low and `sp_out` equals `sp_in`.
- R9: `ccs_out` bits 31:30 equal the input bits 31:30, bits 29:10 equal the input bits 19:0, and bits 9:0 are zero.
- R10: The handler read uses `mem_addr` = `ebp_in` + 4 × vector index. `mem_req` stays high with a stable address until `mem_ack`, and `new_pc` takes `mem_rdata` from the acknowledge cycle.
- R11: An accepted request raises `mem_req` two cycles after acceptance. `done` is high for one cycle, the cycle after the acknowledge. All values used come from the snapshot taken at acceptance, and no request is accepted before the sequencer is idle again.
- R12: A synchronous active-high `rst` returns the sequencer to idle, with `accept`, `mem_req` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pend | input | 1 | Maskable interrupt pending |
| irq_vec | input | VEC_W | Vector index from the interrupt controller |
| irq_lock | input | 1 | Interrupt lock, blocks maskable interrupts |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| brk_req | input | 1 | Break raised by the core |
| brk_vec | input | VEC_W | Trap vector index for break |
| bf_req | input | 1 | Bus fault raised by the core |
| bf_vec | input | VEC_W | Fault vector index for bus fault |
| ccs_in | input | 32 | Current condition/status register |
| ver_in | input | 8 | Version register |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| dslot_in | input | DS_W | Delay-slot count |
| accept | output | 1 | Request taken this cycle |
| cause | output | 2 | Code of the cause taken |
| mem_req | output | 1 | Handler read request |
| mem_addr | output | 32 | Handler read address |
| mem_rdata | input | 32 | Handler read data |
| mem_ack | input | 1 | Handler read acknowledge |
| done | output | 1 | Entry complete, outputs valid |
| new_pc | output | 32 | Handler address |
| ccs_out | output | 32 | Shifted condition/status value |
| exs_out | output | 32 | Exception status value |
| erp_out | output | 32 | Exception return address |
| erp_we | output | 1 | Write enable for erp_out |
| nrp_out | output | 32 | NMI return address |
| nrp_we | output | 1 | Write enable for nrp_out |
| usp_out | output | 32 | Saved user stack pointer |
| usp_we | output | 1 | Write enable for usp_out |
| sp_out | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear the delay-slot count |

## Verification
`accept` and `cause` are combinational and are sampled in the same cycle the request is driven. `mem_req` and `mem_addr` are due two clock edges later. `done` and every register result are due on the edge after the one that sees `mem_ack`, and `done` must be low again one edge after that. The bench waits a fixed number of falling edges from the drive, as these counts set out, before it samples each result, and it changes the core inputs while the sequence runs to show that the snapshot is used. Rejected requests are checked by confirming that `mem_req` stays low for several cycles.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W     = 8,
  parameter int DS_W      = 2,
  parameter int I_BIT     = 6,
  parameter int U_BIT     = 8,
  parameter int M_BIT_OLD = 9,
  parameter int M_BIT_NEW = 30,
  parameter int VER_SPLIT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pend,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             irq_lock,
  input  logic             nmi_pend,
  input  logic             brk_req,
  input  logic [VEC_W-1:0] brk_vec,
  input  logic             bf_req,
  input  logic [VEC_W-1:0] bf_vec,
  input  logic [31:0]      ccs_in,
  input  logic [7:0]       ver_in,
  input  logic [31:0]      pc_in,
  input  logic [31:0]      sp_in,
  input  logic [31:0]      ksp_in,
  input  logic [31:0]      ebp_in,
  input  logic [DS_W-1:0]  dslot_in,
  output logic             accept,
  output logic [1:0]       cause,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             done,
  output logic [31:0]      new_pc,
  output logic [31:0]      ccs_out,
  output logic [31:0]      exs_out,
  output logic [31:0]      erp_out,
  output logic             erp_we,
  output logic [31:0]      nrp_out,
  output logic             nrp_we,
  output logic [31:0]      usp_out,
  output logic             usp_we,
  output logic [31:0]      sp_out,
  output logic             dslot_clr
);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_FETCH, S_DONE} state_t;
  typedef enum logic [1:0] {C_IRQ = 2'd0, C_NMI = 2'd1, C_BRK = 2'd2, C_BF = 2'd3} cause_t;

  state_t           state;
  cause_t           pick, c_cause;
  logic [VEC_W-1:0] pick_vec, c_vec;
  logic [31:0]      c_ccs, c_pc, c_sp, c_ksp, c_ebp;
  logic [DS_W-1:0]  c_ds;
  logic             c_mnew;
  logic             r_erp, r_nrp, r_usp, r_ds;

  logic nmi_on, nmi_ok, irq_ok, any_ok;
  assign nmi_on = (ver_in < VER_SPLIT) ? ccs_in[M_BIT_OLD] : ccs_in[M_BIT_NEW];
  assign nmi_ok = nmi_pend && nmi_on;
  assign irq_ok = irq_pend && ccs_in[I_BIT] && !irq_lock;
  assign any_ok = bf_req || brk_req || nmi_ok || irq_ok;

  always_comb begin
    if (bf_req)       begin pick = C_BF;  pick_vec = bf_vec;  end
    else if (brk_req) begin pick = C_BRK; pick_vec = brk_vec; end
    else if (nmi_ok)  begin pick = C_NMI; pick_vec = '0;      end
    else              begin pick = C_IRQ; pick_vec = irq_vec; end
  end

  assign accept  = !rst && state == S_IDLE && any_ok;
  assign cause   = pick;
  assign mem_req = state == S_FETCH;
  assign done    = state == S_DONE;
  assign erp_we    = done && r_erp;
  assign nrp_we    = done && r_nrp;
  assign usp_we    = done && r_usp;
  assign dslot_clr = done && r_ds;

  logic        is_nmi, in_user;
  logic [31:0] m_mask, ccs_m, ret_addr;
  logic [7:0]  idx8;
  assign is_nmi   = c_cause == C_NMI;
  assign in_user  = c_ccs[U_BIT];
  assign m_mask   = is_nmi ? (32'd1 << (c_mnew ? M_BIT_NEW : M_BIT_OLD)) : 32'd0;
  assign ccs_m    = c_ccs & ~m_mask;
  assign ret_addr = c_pc - 32'(c_ds);
  assign idx8     = 8'(c_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      c_cause <= C_IRQ;
      c_vec <= '0;
      c_ccs <= '0; c_pc <= '0; c_sp <= '0; c_ksp <= '0; c_ebp <= '0;
      c_ds <= '0; c_mnew <= 1'b0;
      r_erp <= 1'b0; r_nrp <= 1'b0; r_usp <= 1'b0; r_ds <= 1'b0;
      mem_addr <= '0; new_pc <= '0; ccs_out <= '0; exs_out <= '0;
      erp_out <= '0; nrp_out <= '0; usp_out <= '0; sp_out <= '0;
    end else begin
      case (state)
        S_IDLE: if (any_ok) begin
          state   <= S_SAVE;
          c_cause <= pick;
          c_vec   <= pick_vec;
          c_ccs   <= ccs_in;
          c_pc    <= pc_in;
          c_sp    <= sp_in;
          c_ksp   <= ksp_in;
          c_ebp   <= ebp_in;
          c_ds    <= dslot_in;
          c_mnew  <= !(ver_in < VER_SPLIT);
        end
        S_SAVE: begin
          state    <= S_FETCH;
          r_erp    <= !is_nmi;
          r_nrp    <= is_nmi;
          r_usp    <= in_user;
          r_ds     <= c_ds != '0;
          if (is_nmi) nrp_out <= ret_addr;
          else        erp_out <= ret_addr;
          if (in_user) usp_out <= c_sp;
          sp_out   <= in_user ? c_ksp : c_sp;
          ccs_out  <= {ccs_m[31:30], ccs_m[19:0], 10'd0};
          exs_out  <= {16'd0, idx8, 8'd0};
          mem_addr <= c_ebp + {{(30-VEC_W){1'b0}}, c_vec, 2'b00};
        end
        S_FETCH: if (mem_ack) begin
          state  <= S_DONE;
          new_pc <= mem_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        accept,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        done,
  input logic        erp_we,
  input logic        nrp_we,
  input logic [31:0] exs_out,
  input logic [31:0] ccs_out
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (mem_req || done) |-> !accept); // R11
  AST_ACCEPT_TO_SAVE: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!accept && !mem_req && !done)); // R11
  AST_EXS_FIELDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (exs_out[31:16] == 16'd0 && exs_out[7:0] == 8'd0)); // R6
  AST_CCS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> ccs_out[9:0] == 10'd0); // R9
  AST_ONE_RETURN_REG: assert property (@(posedge clk) disable iff (rst)
    done |-> (erp_we != nrp_we)); // R4
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk(clk), .rst(rst), .accept(accept), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .done(done), .erp_we(erp_we), .nrp_we(nrp_we),
  .exs_out(exs_out), .ccs_out(ccs_out)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic irq_pend = 0, irq_lock = 0, nmi_pend = 0, brk_req = 0, bf_req = 0;
  logic [7:0] irq_vec = 0, brk_vec = 0, bf_vec = 0, ver_in = 0;
  logic [31:0] ccs_in = 0, pc_in = 0, sp_in = 0, ksp_in = 0, ebp_in = 0, mem_rdata = 0;
  logic [1:0] dslot_in = 0;
  logic mem_ack = 0;
  logic accept, mem_req, done, erp_we, nrp_we, usp_we, dslot_clr;
  logic [1:0] cause;
  logic [31:0] mem_addr, new_pc, ccs_out, exs_out, erp_out, nrp_out, usp_out, sp_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_vec(irq_vec), .irq_lock(irq_lock),
    .nmi_pend(nmi_pend), .brk_req(brk_req), .brk_vec(brk_vec), .bf_req(bf_req),
    .bf_vec(bf_vec), .ccs_in(ccs_in), .ver_in(ver_in), .pc_in(pc_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ebp_in(ebp_in), .dslot_in(dslot_in), .accept(accept),
    .cause(cause), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(done), .new_pc(new_pc), .ccs_out(ccs_out),
    .exs_out(exs_out), .erp_out(erp_out), .erp_we(erp_we), .nrp_out(nrp_out),
    .nrp_we(nrp_we), .usp_out(usp_out), .usp_we(usp_we), .sp_out(sp_out),
    .dslot_clr(dslot_clr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_pos(logic [7:0] ver);
    return (ver < 8'd32) ? 9 : 30;
  endfunction

  function automatic logic [31:0] shift_ccs(logic [31:0] c);
    return {c[31:30], c[19:0], 10'd0};
  endfunction

  task automatic run_case(bit bf, bit brk, bit nmi, bit irq, bit lock,
                          logic [7:0] v_bf, logic [7:0] v_brk, logic [7:0] v_irq,
                          logic [31:0] ccs, logic [7:0] ver, logic [31:0] pc,
                          logic [31:0] sp, logic [31:0] ksp, logic [31:0] ebp,
                          logic [1:0] ds, int ack_dly);
    bit nmi_ok, irq_ok, acc;
    logic [1:0] e_cause;
    logic [7:0] e_vec;
    logic [31:0] e_ccs, e_ret, e_rd;
    @(negedge clk);
    bf_req = bf; brk_req = brk; nmi_pend = nmi; irq_pend = irq; irq_lock = lock;
    bf_vec = v_bf; brk_vec = v_brk; irq_vec = v_irq; ccs_in = ccs; ver_in = ver;
    pc_in = pc; sp_in = sp; ksp_in = ksp; ebp_in = ebp; dslot_in = ds;
    nmi_ok = nmi && ccs[m_pos(ver)];
    irq_ok = irq && ccs[6] && !lock;
    acc = bf || brk || nmi_ok || irq_ok;
    if (bf)          begin e_cause = 2'd3; e_vec = v_bf;  end
    else if (brk)    begin e_cause = 2'd2; e_vec = v_brk; end
    else if (nmi_ok) begin e_cause = 2'd1; e_vec = 8'd0;  end
    else             begin e_cause = 2'd0; e_vec = v_irq; end
    e_ccs = ccs;
    if (e_cause == 2'd1) e_ccs[m_pos(ver)] = 1'b0;
    e_ccs = shift_ccs(e_ccs);
    e_ret = pc - 32'(ds);
    #1;
    chk("R3 accept", 32'(accept), 32'(acc));
    if (!acc) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R1 R2 rejected request starts nothing", 32'(mem_req), 32'd0);
      end
      bf_req = 0; brk_req = 0; nmi_pend = 0; irq_pend = 0;
      return;
    end
    chk("R3 cause", 32'(cause), 32'(e_cause));
    @(negedge clk);
    bf_req = 0; brk_req = 0; nmi_pend = 1; irq_pend = 1; irq_lock = 0;
    ccs_in = $urandom | 32'h4000_0240; pc_in = $urandom; sp_in = $urandom;
    ksp_in = $urandom; ebp_in = $urandom; dslot_in = 2'($urandom);
    #1 chk("R11 busy ignores requests", 32'(accept), 32'd0);
    @(negedge clk);
    chk("R11 mem_req two cycles after accept", 32'(mem_req), 32'd1);
    chk("R10 handler address", mem_addr, ebp + 32'(e_vec) * 4);
    for (int i = 0; i < ack_dly; i++) begin
      @(negedge clk);
      chk("R10 request held", 32'(mem_req), 32'd1);
      chk("R11 busy ignores requests", 32'(accept), 32'd0);
    end
    e_rd = $urandom;
    mem_ack = 1; mem_rdata = e_rd;
    @(negedge clk);
    mem_ack = 0; mem_rdata = $urandom;
    chk("R11 done after ack", 32'(done), 32'd1);
    chk("R10 new_pc", new_pc, e_rd);
    chk("R9 ccs shift", ccs_out, e_ccs);
    chk("R6 exs", exs_out, {16'd0, e_vec, 8'd0});
    chk("R7 dslot_clr", 32'(dslot_clr), 32'(ds != 0));
    chk("R8 usp_we", 32'(usp_we), 32'(ccs[8]));
    chk("R8 sp_out", sp_out, ccs[8] ? ksp : sp);
    if (ccs[8]) chk("R8 usp_out", usp_out, sp);
    if (e_cause == 2'd1) begin
      chk("R4 nrp_we", 32'(nrp_we), 32'd1);
      chk("R4 erp_we low", 32'(erp_we), 32'd0);
      chk("R4 R7 nrp_out", nrp_out, e_ret);
    end else begin
      chk("R5 erp_we", 32'(erp_we), 32'd1);
      chk("R5 nrp_we low", 32'(nrp_we), 32'd0);
      chk("R5 R7 erp_out", erp_out, e_ret);
    end
    nmi_pend = 0; irq_pend = 0;
    @(negedge clk);
    chk("R11 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    bf_req = 1; nmi_pend = 1; ccs_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset accept", 32'(accept), 32'd0);
    chk("R12 reset mem_req", 32'(mem_req), 32'd0);
    chk("R12 reset done", 32'(done), 32'd0);
    @(negedge clk);
    bf_req = 0; nmi_pend = 0; ccs_in = 0;
    rst = 0;
    // R1: interrupt taken, then blocked by lock and by cleared enable
    run_case(0,0,0,1,0, 8'h00,8'h00,8'h21, 32'h0000_0040, 8'd40, 32'h1000, 32'hA0,32'hB0, 32'h8000_0000, 2'd0, 0);
    run_case(0,0,0,1,1, 8'h00,8'h00,8'h21, 32'h0000_0040, 8'd40, 32'h1000, 32'hA0,32'hB0, 32'h8000_0000, 2'd0, 0);
    run_case(0,0,0,1,0, 8'h00,8'h00,8'h21, 32'hFFFF_FFBF, 8'd40, 32'h1000, 32'hA0,32'hB0, 32'h8000_0000, 2'd0, 0);
    // R2 R4: old-version enable bit 9, new-version enable bit 30
    run_case(0,0,1,0,0, 8'h00,8'h00,8'h00, 32'h0000_0200, 8'd10, 32'h2000, 32'hA0,32'hB0, 32'h4000, 2'd0, 1);
    run_case(0,0,1,0,0, 8'h00,8'h00,8'h00, 32'h4000_0000, 8'd10, 32'h2000, 32'hA0,32'hB0, 32'h4000, 2'd0, 1);
    run_case(0,0,1,0,0, 8'h00,8'h00,8'h00, 32'h4000_0000, 8'd32, 32'h2000, 32'hA0,32'hB0, 32'h4000, 2'd0, 1);
    run_case(0,0,1,0,0, 8'h00,8'h00,8'h00, 32'h0000_0200, 8'd32, 32'h2000, 32'hA0,32'hB0, 32'h4000, 2'd0, 1);
    // R3: priorities
    run_case(0,0,1,1,0, 8'h00,8'h00,8'h33, 32'h4000_0240, 8'd50, 32'h3000, 32'h1,32'h2, 32'h100, 2'd1, 2);
    run_case(1,1,1,1,0, 8'h44,8'h55,8'h33, 32'h4000_0240, 8'd50, 32'h3000, 32'h1,32'h2, 32'h100, 2'd0, 0);
    run_case(0,1,1,1,0, 8'h44,8'h55,8'h33, 32'h4000_0240, 8'd50, 32'h3000, 32'h1,32'h2, 32'h100, 2'd0, 0);
    // R7 R8: delay-slot correction, user mode swap, top vector
    run_case(0,1,0,0,0, 8'h00,8'hFF,8'h00, 32'hC00F_FFFF, 8'd3, 32'h0000_0002, 32'h7777,32'h9999, 32'hFFFF_FF00, 2'd3, 3);
    run_case(1,0,0,0,0, 8'h80,8'h00,8'h00, 32'h0000_0100, 8'd3, 32'h5000, 32'h7777,32'h9999, 32'h0, 2'd2, 0);
    for (int n = 0; n < 300; n++) begin
      run_case(($urandom % 5) == 0, ($urandom % 5) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
               8'($urandom), 8'($urandom), 8'($urandom), $urandom, 8'($urandom % 64),
               $urandom, $urandom, $urandom, $urandom, 2'($urandom), $urandom % 4);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule